// File: doc/BRIEF.md
# Pipelined Composite-Field AES Byte Substitution

This block computes the forward AES byte substitution arithmetically instead of reading it from a 256-entry table. Each incoming byte is carried by a linear change of basis from the standard field GF(2^8) into a tower field GF((2^4)^2). In the tower field the multiplicative inverse is found with a few multiplications, squarings and one inversion in GF(2^4). A second linear map, which also folds in the affine step, then produces the substituted byte. Every value held between stages is a 4-bit nibble.

The datapath is cut into five register stages. It accepts one byte on every clock and returns its substitute exactly five clocks later, together with a valid flag. To reach full rate the caller must keep bytes arriving every cycle. Gaps in the valid stream are allowed and simply travel down the pipeline as bubbles. It is meant to be instanced sixteen times per round in a deeply pipelined cipher core.

Top module: `aes_cf_sbox`

## Requirements
- R1: For every input byte `x`, `res_byte` equals the standard AES forward substitution of `x`: the inverse of `x` in GF(2^8) modulo x^8+x^4+x^3+x+1, with zero taken as its own inverse, followed by the affine transform b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63.
- R2: Latency is exactly five clock edges: a byte sampled with `arg_vld` high at edge k appears with `res_vld` high after edge k+4 and can be read before edge k+5. `res_vld` is never high one cycle earlier or later.
- R3: A new byte may be presented on every consecutive cycle. Each result depends only on its own input byte, with no interference from the bytes next to it.
- R4: Input 0x00 produces 0x63.
- R5: While `rst_n` is low, and after it rises until the first valid byte has passed through, `res_vld` is low. Asserting `rst_n` low in the middle of a stream drops every byte that was in flight.
- R6: A cycle with `arg_vld` low produces `res_vld` low five cycles later, whatever value `arg_byte` holds in that cycle.
- R7: Every intermediate operand is 4 bits wide. For a nonzero input, the GF(2^4) norm is nonzero, and the norm times its computed inverse equals 1.
- R8: When valid bytes arrive with idle cycles between them, each valid byte still emerges with the correct substitute exactly five cycles after it was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| arg_vld | input | 1 | Qualifies `arg_byte` in this cycle |
| arg_byte | input | 8 | Byte to substitute |
| res_vld | output | 1 | Qualifies `res_byte` |
| res_byte | output | 8 | Substituted byte |

## Verification
The latency and zero-input properties compare present outputs with inputs from five cycles earlier. They rely on a warm-up counter, so they are only enforced after five clean edges have followed reset. They also assume `arg_byte` carries a known value on every cycle, including idle ones. The stimulus therefore drives `arg_byte` to a defined value at all times, and it applies inputs only on the falling edge, so the sampled values are stable. The field checks on the norm and its inverse assume that a valid byte is zero exactly when both of its tower-field halves are zero. This is true of any invertible change of basis, and the full sweep of all 256 inputs exercises it.

// File: rtl/aes_cf_pkg.sv
package aes_cf_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // GF(2^4) product, modulus x^4 + x + 1
  function automatic nib_t gf4_mul(input nib_t a, input nib_t b);
    nib_t acc;
    nib_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < NIB_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[2:0], 1'b0} ^ (sh[3] ? 4'h3 : 4'h0);
    end
    return acc;
  endfunction

  function automatic nib_t gf4_sq(input nib_t a);
    return gf4_mul(a, a);
  endfunction

  // a^14 = a^-1 in GF(16); zero stays zero
  function automatic nib_t gf4_inv(input nib_t a);
    nib_t a2, a4, a8;
    a2 = gf4_sq(a);
    a4 = gf4_sq(a2);
    a8 = gf4_sq(a4);
    return gf4_mul(gf4_mul(a8, a4), a2);
  endfunction

  // smallest constant making y^2 + y + c irreducible over GF(16)
  function automatic nib_t pick_lambda();
    for (int c = 1; c < 16; c++) begin
      bit has_root;
      has_root = 1'b0;
      for (int t = 0; t < 16; t++)
        if ((gf4_sq(nib_t'(t)) ^ nib_t'(t)) == nib_t'(c)) has_root = 1'b1;
      if (!has_root) return nib_t'(c);
    end
    return '0;
  endfunction

  localparam nib_t CF_LAMBDA = pick_lambda();

  // tower product, element = hi*y + lo, y^2 = y + lambda
  function automatic byte_t cf_mul(input byte_t a, input byte_t b);
    nib_t hh, hi, lo;
    hh = gf4_mul(a[7:4], b[7:4]);
    hi = hh ^ gf4_mul(a[7:4], b[3:0]) ^ gf4_mul(a[3:0], b[7:4]);
    lo = gf4_mul(hh, CF_LAMBDA) ^ gf4_mul(a[3:0], b[3:0]);
    return {hi, lo};
  endfunction

  function automatic byte_t cf_pow(input byte_t g, input int e);
    byte_t r;
    r = 8'h01;
    for (int i = 0; i < e; i++) r = cf_mul(r, g);
    return r;
  endfunction

  // tower element that is a root of the AES modulus
  function automatic byte_t find_root();
    for (int g = 2; g < 256; g++) begin
      byte_t gb;
      gb = byte_t'(g);
      if ((cf_pow(gb, 8) ^ cf_pow(gb, 4) ^ cf_pow(gb, 3) ^ gb ^ 8'h01) == 8'h00)
        return gb;
    end
    return '0;
  endfunction

  localparam byte_t CF_ROOT = find_root();

  function automatic logic [63:0] enter_cols();
    logic [63:0] c;
    for (int i = 0; i < BYTE_W; i++) c[i*8 +: 8] = cf_pow(CF_ROOT, i);
    return c;
  endfunction

  localparam logic [63:0] ENTER_COLS = enter_cols();

  function automatic byte_t enter_map(input byte_t x);
    byte_t acc;
    acc = '0;
    for (int i = 0; i < BYTE_W; i++) if (x[i]) acc = acc ^ ENTER_COLS[i*8 +: 8];
    return acc;
  endfunction

  function automatic byte_t affine_lin(input byte_t a);
    byte_t b;
    for (int i = 0; i < BYTE_W; i++)
      b[i] = a[i] ^ a[(i+4)%8] ^ a[(i+5)%8] ^ a[(i+6)%8] ^ a[(i+7)%8];
    return b;
  endfunction

  // column j: affine of the standard element whose image is unit vector j
  function automatic logic [63:0] leave_cols();
    logic [63:0] c;
    c = '0;
    for (int j = 0; j < BYTE_W; j++)
      for (int x = 0; x < 256; x++)
        if (enter_map(byte_t'(x)) == byte_t'(1 << j)) c[j*8 +: 8] = affine_lin(byte_t'(x));
    return c;
  endfunction

  localparam logic [63:0] LEAVE_COLS = leave_cols();
  localparam byte_t AFFINE_OFS = 8'h63;

endpackage

// File: rtl/cf_lin_map.sv
module cf_lin_map
  import aes_cf_pkg::*;
#(
  parameter logic [63:0] COLS   = 64'h0,
  parameter byte_t       OFFSET = 8'h00
) (
  input  byte_t din,
  output byte_t dout
);
  always_comb begin
    dout = OFFSET;
    for (int i = 0; i < BYTE_W; i++)
      if (din[i]) dout = dout ^ COLS[i*8 +: 8];
  end
endmodule

// File: rtl/cf_norm.sv
module cf_norm
  import aes_cf_pkg::*;
(
  input  nib_t hi,
  input  nib_t lo,
  output nib_t norm
);
  // hi^2*lambda + hi*lo + lo^2
  assign norm = gf4_mul(gf4_sq(hi), CF_LAMBDA) ^ gf4_mul(hi, lo) ^ gf4_sq(lo);
endmodule

// File: rtl/cf_nib_inv.sv
module cf_nib_inv
  import aes_cf_pkg::*;
(
  input  nib_t a,
  output nib_t a_inv
);
  assign a_inv = gf4_inv(a);
endmodule

// File: rtl/cf_scale.sv
module cf_scale
  import aes_cf_pkg::*;
(
  input  nib_t hi,
  input  nib_t lo,
  input  nib_t ninv,
  output nib_t inv_hi,
  output nib_t inv_lo
);
  assign inv_hi = gf4_mul(hi, ninv);
  assign inv_lo = gf4_mul(hi ^ lo, ninv);
endmodule

// File: rtl/aes_cf_sbox.sv
module aes_cf_sbox
  import aes_cf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arg_vld,
  input  logic [7:0] arg_byte,
  output logic       res_vld,
  output logic [7:0] res_byte
);
  localparam int DEPTH = 5;
  localparam int CNT_W = $clog2(DEPTH + 1);

  // stage wires
  byte_t mapped_w;
  nib_t  norm_w, ninv_w, ih_w, il_w;
  byte_t leave_w;

  // stage registers
  logic s1_vld, s2_vld, s3_vld, s4_vld;
  nib_t s1_hi, s1_lo;
  nib_t s2_hi, s2_lo, s2_norm;
  nib_t s3_hi, s3_lo, s3_ninv;
  nib_t s4_ih, s4_il;

  cf_lin_map #(.COLS(ENTER_COLS), .OFFSET(8'h00)) u_enter (
    .din (arg_byte),
    .dout(mapped_w)
  );

  cf_norm u_norm (.hi(s1_hi), .lo(s1_lo), .norm(norm_w));

  cf_nib_inv u_ninv (.a(s2_norm), .a_inv(ninv_w));

  cf_scale u_scale (
    .hi    (s3_hi),
    .lo    (s3_lo),
    .ninv  (s3_ninv),
    .inv_hi(ih_w),
    .inv_lo(il_w)
  );

  cf_lin_map #(.COLS(LEAVE_COLS), .OFFSET(AFFINE_OFS)) u_leave (
    .din ({s4_ih, s4_il}),
    .dout(leave_w)
  );

  // valid chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s2_vld  <= 1'b0;
      s3_vld  <= 1'b0;
      s4_vld  <= 1'b0;
      res_vld <= 1'b0;
    end else begin
      s1_vld  <= arg_vld;
      s2_vld  <= s1_vld;
      s3_vld  <= s2_vld;
      s4_vld  <= s3_vld;
      res_vld <= s4_vld;
    end
  end

  // data chain, no reset needed
  always_ff @(posedge clk) begin
    s1_hi    <= mapped_w[7:4];
    s1_lo    <= mapped_w[3:0];
    s2_hi    <= s1_hi;
    s2_lo    <= s1_lo;
    s2_norm  <= norm_w;
    s3_hi    <= s2_hi;
    s3_lo    <= s2_lo;
    s3_ninv  <= ninv_w;
    s4_ih    <= ih_w;
    s4_il    <= il_w;
    res_byte <= leave_w;
  end

  // checking support: edges seen since reset, saturating
  logic [CNT_W-1:0] warm_cnt;
  logic             warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       warm_cnt <= '0;
    else if (warm_cnt != CNT_W'(DEPTH)) warm_cnt <= warm_cnt + 1'b1;
  end
  assign warm = (warm_cnt == CNT_W'(DEPTH));

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (res_vld == $past(arg_vld, 5)));  // R2

  AST_ZERO_TO_63: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && res_vld && $past(arg_byte, 5) == 8'h00) |-> (res_byte == 8'h63));  // R4

  AST_NORM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && {s1_hi, s1_lo} != 8'h00) |-> (norm_w != 4'h0));  // R7

  AST_NIB_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_vld && s2_norm != 4'h0) |-> (gf4_mul(s2_norm, ninv_w) == 4'h1));  // R7

  AST_BUBBLE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !s4_vld |=> !res_vld);  // R6

endmodule

// File: tb/aes_cf_sbox_test.sv
module aes_cf_sbox_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       arg_vld;
  logic [7:0] arg_byte;
  logic       res_vld;
  logic [7:0] res_byte;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [7:0] ref_tab [256];
  logic       stim_v  [300];
  logic [7:0] stim_d  [300];

  always #2 clk = ~clk;  // 250 MHz

  aes_cf_sbox uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .arg_vld (arg_vld),
    .arg_byte(arg_byte),
    .res_vld (res_vld),
    .res_byte(res_byte)
  );

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 8'h00;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int k);
    return (v << k) | (v >> (8 - k));
  endfunction

  task automatic build_ref();
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (gmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      ref_tab[x] = inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
    end
  endtask

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_stream(input int n, input string req);
    for (int i = 0; i < n + 5; i++) begin
      @(negedge clk);
      if (i >= 5) begin
        chk({req, " valid"}, {8'h00, res_vld}, {8'h00, stim_v[i-5]});
        if (stim_v[i-5]) chk({req, " data"}, {1'b0, res_byte}, {1'b0, ref_tab[stim_d[i-5]]});
      end else begin
        chk({req, " valid idle"}, {8'h00, res_vld}, 9'h000);
      end
      arg_vld  = (i < n) ? stim_v[i] : 1'b0;
      arg_byte = (i < n) ? stim_d[i] : 8'h00;
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; arg_vld = 1'b0; arg_byte = 8'h00;
    repeat (3) @(negedge clk);
    chk("R5 during reset", {8'h00, res_vld}, 9'h000);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R5 after reset", {8'h00, res_vld}, 9'h000);
    end
  endtask

  task automatic t_sweep_up();  // R1 R3 R7
    for (int i = 0; i < 256; i++) begin stim_v[i] = 1'b1; stim_d[i] = 8'(i); end
    run_stream(256, "R1/R3/R7 sweep up");
  endtask

  task automatic t_sweep_down();  // R3: reversed neighbours
    for (int i = 0; i < 256; i++) begin stim_v[i] = 1'b1; stim_d[i] = 8'(255 - i); end
    run_stream(256, "R3 sweep down");
  endtask

  task automatic t_zero();  // R4
    for (int i = 0; i < 4; i++) begin stim_v[i] = 1'b1; stim_d[i] = 8'h00; end
    run_stream(4, "R4 zero");
    stim_v[0] = 1'b1; stim_d[0] = 8'h00;
    run_stream(1, "R4 lone zero");
  endtask

  task automatic t_latency();  // R2: single pulse, valid checked every cycle
    stim_v[0] = 1'b1; stim_d[0] = 8'h53;
    for (int i = 1; i < 8; i++) begin stim_v[i] = 1'b0; stim_d[i] = 8'hFF; end
    run_stream(8, "R2 single pulse");
    chk("R2 known value 53", {1'b0, ref_tab[8'h53]}, 9'h0ED);
  endtask

  task automatic t_gaps();  // R6 R8
    for (int i = 0; i < 60; i++) begin
      stim_v[i] = (i % 3) != 0;
      stim_d[i] = 8'(i * 37 + 11);
    end
    run_stream(60, "R6/R8 gapped");
  endtask

  task automatic t_reset_mid();  // R5
    @(negedge clk);
    arg_vld = 1'b1;
    for (int i = 0; i < 4; i++) begin
      arg_byte = 8'(i + 1);
      @(negedge clk);
    end
    arg_vld = 1'b0; arg_byte = 8'h00;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R5 mid-stream reset", {8'h00, res_vld}, 9'h000);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      chk("R5 flushed after reset", {8'h00, res_vld}, 9'h000);
    end
  endtask

  initial begin
    build_ref();
    t_reset_state();
    t_latency();
    t_zero();
    t_sweep_up();
    t_sweep_down();
    t_gaps();
    t_reset_mid();
    t_sweep_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule